// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block decides when an SDRAM controller must stop serving accesses to refresh the memory. A down-counter, reloaded from a programmable rate divider, raises a refresh request when it runs out. The sequencer answers each request with a precharge-all command, waits the row precharge time, and issues an auto-refresh. It then holds off any new row activation until the refresh recovery time (row active time plus row precharge time) has passed. Only one request can be pending. If an access is in flight when the request arrives, the request waits until the access finishes.

Software can also put the memory into self-refresh. A one-cycle write strobe sets a sticky enable bit. Once no access is in flight, the sequencer drops clock-enable. While clock-enable is low, the block issues no commands and the interval counter is frozen. The device stays in this state for at least the row active time, and it wakes only when an access is requested. The wake-up path runs in this order: clock-enable rises, the block waits the exit time, then runs a precharge-all and auto-refresh pair, waits the recovery time, and finally grants the access that woke the device. The enable bit clears when the wake-up starts.

The access side is a simple handshake. The requester holds `acc_req` until it sees an activate grant on `cmd`. It then marks the end of its transfer with a one-cycle `acc_done`.

Top module: `sdram_refresh_seq`

## Requirements
- R1: Command encoding on `cmd` is 0 = NOP, 1 = precharge-all, 2 = auto-refresh, 3 = activate grant. When the block is idle, the interval counter reloads with `cfg_rate_div` (D) at every auto-refresh. The next auto-refresh follows exactly D + tRP + 4 cycles later.
- R2: Every auto-refresh comes exactly tRP + 1 cycles after a precharge-all, and no other command appears between the two.
- R3: An activate grant never comes earlier than tRFC + 1 cycles after an auto-refresh, where tRFC = `cfg_tras` + `cfg_trp`.
- R4: A pulse on `sr_set` sets `sr_enable`. If an access is in flight, `cke` stays high until it completes. `cke` then falls two cycles after the `acc_done` cycle.
- R5: While `cke` is low, `cmd` stays NOP, so no refresh is issued.
- R6: `cke` stays low for at least tRAS cycles. It stays low indefinitely while no access is requested. When the request is already present at entry, `cke` stays low for exactly tRAS cycles.
- R7: On exit, precharge-all comes exactly tRAS + tRP cycles after `cke` rises. The auto-refresh follows tRP + 1 cycles later, and the grant for the waking access follows exactly tRFC + 1 cycles after that.
- R8: `sr_enable` is clear once exit has begun. Without a new `sr_set`, the block does not enter self-refresh again.
- R9: A refresh that falls due during an access issues no command until `acc_done`. Precharge-all then comes two cycles after the `acc_done` cycle, and exactly one refresh pair follows, however many intervals the access spanned.
- R10: `acc_busy` is high during the precharge, refresh and recovery steps. A request made during those steps is not granted while they last.
- R11: After reset, `cmd` is NOP, `cke` is high, and both `acc_busy` and `sr_enable` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rate_div | input | DIV_W | Refresh interval reload value |
| cfg_tras | input | TCNT_W | Row active time in cycles (at least 2) |
| cfg_trp | input | TCNT_W | Row precharge time in cycles (at least 1) |
| sr_set | input | 1 | One-cycle strobe that requests self-refresh |
| acc_req | input | 1 | Access request, held until granted |
| acc_done | input | 1 | One-cycle end-of-access strobe |
| cmd | output | 2 | Command: NOP, precharge-all, auto-refresh, activate |
| cke | output | 1 | SDRAM clock-enable |
| acc_busy | output | 1 | High whenever the sequencer is not idle |
| sr_enable | output | 1 | Sticky self-refresh enable bit |

## Verification
The assertions rely on these input assumptions:
- The three configuration inputs hold steady between resets.
- tRAS is at least 2 and tRP is at least 1.
- `acc_req` stays high until a grant.
- `acc_done` arrives only while an access is in flight.

The bench follows these rules by design. It changes the configuration only while reset is applied. It drops the request only after observing the grant. It issues exactly one `acc_done` pulse per granted access. It keeps the divider well above the recovery time, so refresh requests never overlap the sequence that answers them.

// File: rtl/srs_pkg.sv
// Package srs_pkg
// Shared encodings for the refresh sequencer: the command bus values and
// the sequencer state. The command values are visible at the top port.
package srs_pkg;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'd0,
        CMD_PRE_ALL = 2'd1,
        CMD_AREF    = 2'd2,
        CMD_ACT     = 2'd3
    } srs_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GRANT,
        ST_ACCESS,
        ST_PRE,
        ST_PRE_WAIT,
        ST_AREF,
        ST_RFC_WAIT,
        ST_SELF,
        ST_XSR_WAIT
    } srs_state_e;

endpackage

// File: rtl/srs_interval_timer.sv
// Module srs_interval_timer
// Counts down from the rate divider and raises a single sticky refresh
// request when the count reaches zero. A reload (issued with every
// auto-refresh) restores the count and clears the request. While frozen
// the count and request hold their values.
// Assumes: rate_div is stable between resets.
module srs_interval_timer #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] rate_div,
    input  logic             reload,
    input  logic             freeze,
    output logic             pend
);

    logic [DIV_W-1:0] cnt;

    // Interval count and the one-deep pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= rate_div;
            pend <= 1'b0;
        end else if (reload) begin
            cnt  <= rate_div;
            pend <= 1'b0;
        end else if (!freeze) begin
            if (cnt == '0) begin
                pend <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    AST_EXPIRY_RAISES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !freeze && !reload) |=> pend); // R1

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !reload) |=> $stable(cnt)); // R5

endmodule

// File: rtl/srs_wait_cnt.sv
// Module srs_wait_cnt
// A shared delay counter. A load of N makes zero assert N-1 cycles later,
// so a state that loads on entry and leaves on zero lasts N cycles.
// Assumes: load_val is at least 1.
module srs_wait_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Load or count down, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R2

endmodule

// File: rtl/srs_seq_fsm.sv
// Module srs_seq_fsm
// Main sequencer. It orders refresh pairs, self-refresh entry and exit,
// and access grants, and it drives the command, clock-enable and busy
// outputs from its state. Idle priority is: pending refresh first, then
// self-refresh entry, then the access grant.
// Assumes: configuration stable between resets, tras >= 2, trp >= 1,
// acc_req held until grant, acc_done only while an access is in flight.
module srs_seq_fsm
    import srs_pkg::*;
#(
    parameter int TCNT_W = 5,
    parameter int WW     = TCNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TCNT_W-1:0] cfg_tras,
    input  logic [TCNT_W-1:0] cfg_trp,
    input  logic              pend,
    input  logic              wait_zero,
    input  logic              acc_req,
    input  logic              acc_done,
    input  logic              sr_set,
    output srs_cmd_e          cmd,
    output logic              cke,
    output logic              busy,
    output logic              sr_en,
    output logic              wait_load,
    output logic [WW-1:0]     wait_val,
    output logic              reload,
    output logic              freeze
);

    localparam int SW = WW + 1;

    srs_state_e     st, st_nx;
    logic           exit_pend;
    logic           exit_set;
    logic [WW-1:0]  t_ras;
    logic [WW-1:0]  t_rp;
    logic [WW-1:0]  t_rfc;
    srs_cmd_e       last_cmd;
    logic [SW-1:0]  since_aref;
    logic           seen_aref;
    logic [SW-1:0]  low_cnt;

    assign t_ras = {1'b0, cfg_tras};
    assign t_rp  = {1'b0, cfg_trp};
    assign t_rfc = t_ras + t_rp;

    // Next-state, wait-counter load and exit-marking decisions.
    always_comb begin
        st_nx     = st;
        wait_load = 1'b0;
        wait_val  = '0;
        exit_set  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (pend) begin
                    st_nx = ST_PRE;
                end else if (sr_en) begin
                    st_nx     = ST_SELF;
                    wait_load = 1'b1;
                    wait_val  = t_ras;
                end else if (acc_req) begin
                    st_nx = ST_GRANT;
                end
            end
            ST_GRANT:  st_nx = ST_ACCESS;
            ST_ACCESS: if (acc_done) st_nx = ST_IDLE;
            ST_PRE: begin
                st_nx     = ST_PRE_WAIT;
                wait_load = 1'b1;
                wait_val  = t_rp;
            end
            ST_PRE_WAIT: if (wait_zero) st_nx = ST_AREF;
            ST_AREF: begin
                st_nx     = ST_RFC_WAIT;
                wait_load = 1'b1;
                wait_val  = t_rfc;
            end
            ST_RFC_WAIT: begin
                if (wait_zero) st_nx = exit_pend ? ST_GRANT : ST_IDLE;
            end
            ST_SELF: begin
                if (wait_zero && acc_req) begin
                    st_nx     = ST_XSR_WAIT;
                    wait_load = 1'b1;
                    wait_val  = t_rfc;
                    exit_set  = 1'b1;
                end
            end
            ST_XSR_WAIT: if (wait_zero) st_nx = ST_PRE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Marks that the running refresh pair belongs to a self-refresh exit.
    always_ff @(posedge clk) begin
        if (!rst_n)              exit_pend <= 1'b0;
        else if (exit_set)       exit_pend <= 1'b1;
        else if (st == ST_GRANT) exit_pend <= 1'b0;
    end

    // Sticky self-refresh enable: set by software, cleared as exit starts.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_en <= 1'b0;
        else if (exit_set) sr_en <= 1'b0;
        else if (sr_set)   sr_en <= 1'b1;
    end

    // Command decode from state.
    always_comb begin
        unique case (st)
            ST_PRE:   cmd = CMD_PRE_ALL;
            ST_AREF:  cmd = CMD_AREF;
            ST_GRANT: cmd = CMD_ACT;
            default:  cmd = CMD_NOP;
        endcase
    end

    assign cke    = (st != ST_SELF);
    assign busy   = (st != ST_IDLE);
    assign reload = (st == ST_AREF);
    assign freeze = (st == ST_SELF);

    // Tracking used by the assertions: last non-NOP command seen.
    always_ff @(posedge clk) begin
        if (!rst_n)              last_cmd <= CMD_NOP;
        else if (cmd != CMD_NOP) last_cmd <= cmd;
    end

    // Tracking: cycles since the latest auto-refresh, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_aref <= '0;
            seen_aref  <= 1'b0;
        end else if (cmd == CMD_AREF) begin
            since_aref <= '0;
            seen_aref  <= 1'b1;
        end else if (since_aref != '1) begin
            since_aref <= since_aref + 1'b1;
        end
    end

    // Tracking: length of the current clock-enable low period, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                    low_cnt <= '0;
        else if (cke)                  low_cnt <= '0;
        else if (low_cnt != '1)        low_cnt <= low_cnt + 1'b1;
    end

    AST_PRE_BEFORE_AREF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_AREF) |-> (last_cmd == CMD_PRE_ALL)); // R2

    AST_RFC_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && seen_aref) |-> (since_aref >= SW'(t_rfc))); // R3

    AST_CKE_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> ($past(st) == ST_IDLE)); // R4

    AST_SELF_MIN_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (low_cnt >= SW'(t_ras))); // R6

    AST_EXIT_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> !sr_en); // R8

endmodule

// File: rtl/sdram_refresh_seq.sv
// Module sdram_refresh_seq
// Top of the refresh and self-refresh sequencer. It connects the interval
// timer, the shared delay counter and the sequencer, and exposes the
// command bus, clock-enable and the access handshake.
// Assumes: configuration stable between resets, cfg_tras >= 2,
// cfg_trp >= 1, cfg_rate_div well above cfg_tras + cfg_trp.
module sdram_refresh_seq
    import srs_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int TCNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_rate_div,
    input  logic [TCNT_W-1:0] cfg_tras,
    input  logic [TCNT_W-1:0] cfg_trp,
    input  logic              sr_set,
    input  logic              acc_req,
    input  logic              acc_done,
    output logic [1:0]        cmd,
    output logic              cke,
    output logic              acc_busy,
    output logic              sr_enable
);

    localparam int WW = TCNT_W + 1;

    srs_cmd_e       cmd_e;
    logic           pend;
    logic           wait_zero;
    logic           wait_load;
    logic [WW-1:0]  wait_val;
    logic           reload;
    logic           freeze;

    srs_interval_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_div (cfg_rate_div),
        .reload   (reload),
        .freeze   (freeze),
        .pend     (pend)
    );

    srs_wait_cnt #(.W(WW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .zero     (wait_zero)
    );

    srs_seq_fsm #(.TCNT_W(TCNT_W), .WW(WW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_tras  (cfg_tras),
        .cfg_trp   (cfg_trp),
        .pend      (pend),
        .wait_zero (wait_zero),
        .acc_req   (acc_req),
        .acc_done  (acc_done),
        .sr_set    (sr_set),
        .cmd       (cmd_e),
        .cke       (cke),
        .busy      (acc_busy),
        .sr_en     (sr_enable),
        .wait_load (wait_load),
        .wait_val  (wait_val),
        .reload    (reload),
        .freeze    (freeze)
    );

    assign cmd = cmd_e;

    AST_QUIET_IN_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd == 2'd0)); // R5

    AST_NOT_BUSY_IDLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 2'd0) |-> acc_busy); // R10

endmodule

// File: tb/sdram_refresh_seq_test.sv
module sdram_refresh_seq_test;

    localparam int DIV_W  = 12;
    localparam int TCNT_W = 5;

    typedef struct packed {
        logic [15:0] div;
        logic [15:0] tras;
        logic [15:0] trp;
        logic [15:0] gap;
    } vec_t;

    // Stimulus (divider, tRAS, tRP) and expected auto-refresh spacing D+tRP+4.
    localparam vec_t VECS [0:3] = '{
        '{16'd20, 16'd3, 16'd2, 16'd26},
        '{16'd30, 16'd4, 16'd1, 16'd35},
        '{16'd12, 16'd2, 16'd3, 16'd19},
        '{16'd50, 16'd6, 16'd4, 16'd58}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  cfg_rate_div = 12'd20;
    logic [TCNT_W-1:0] cfg_tras = 5'd3;
    logic [TCNT_W-1:0] cfg_trp = 5'd2;
    logic              sr_set = 1'b0;
    logic              acc_req = 1'b0;
    logic              acc_done = 1'b0;
    logic [1:0]        cmd;
    logic              cke;
    logic              acc_busy;
    logic              sr_enable;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Monitor state, updated at each falling edge.
    int cyc = 0;
    int n_pre = 0, n_aref = 0, n_act = 0, n_low_cmd = 0;
    int pre_cyc = 0, aref_cyc = 0, act_cyc = 0, rise_cyc = 0, fall_cyc = 0;
    logic cke_q = 1'b1;

    sdram_refresh_seq #(.DIV_W(DIV_W), .TCNT_W(TCNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_rate_div(cfg_rate_div),
        .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .sr_set(sr_set),
        .acc_req(acc_req), .acc_done(acc_done), .cmd(cmd), .cke(cke),
        .acc_busy(acc_busy), .sr_enable(sr_enable)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cmd == 2'd1) begin n_pre = n_pre + 1; pre_cyc = cyc; end
        if (cmd == 2'd2) begin n_aref = n_aref + 1; aref_cyc = cyc; end
        if (cmd == 2'd3) begin n_act = n_act + 1; act_cyc = cyc; end
        if (!cke && cmd != 2'd0) n_low_cmd = n_low_cmd + 1;
        if (cke && !cke_q) rise_cyc = cyc;
        if (!cke && cke_q) fall_cyc = cyc;
        cke_q = cke;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic wait_aref();
        int start;
        start = n_aref;
        while (n_aref == start) tick(1);
    endtask

    task automatic wait_grant();
        int start;
        start = n_act;
        acc_req = 1'b1;
        while (n_act == start) tick(1);
        acc_req = 1'b0;
    endtask

    task automatic finish_access(output int done_c);
        done_c = cyc;
        acc_done = 1'b1;
        tick(1);
        acc_done = 1'b0;
    endtask

    task automatic pulse_sr();
        sr_set = 1'b1;
        tick(1);
        sr_set = 1'b0;
    endtask

    initial begin
        int a1, dc, p0, r0, l0;
        tick(1);

        // Vector table: spacing of idle refreshes and precharge lead.
        for (int v = 0; v < 4; v++) begin
            cfg_rate_div = VECS[v].div[DIV_W-1:0];
            cfg_tras     = VECS[v].tras[TCNT_W-1:0];
            cfg_trp      = VECS[v].trp[TCNT_W-1:0];
            do_reset();
            wait_aref();
            a1 = aref_cyc;
            check(aref_cyc - pre_cyc == int'(VECS[v].trp) + 1, "R2",
                  aref_cyc - pre_cyc, int'(VECS[v].trp) + 1);
            wait_aref();
            check(aref_cyc - a1 == int'(VECS[v].gap), "R1",
                  aref_cyc - a1, int'(VECS[v].gap));
        end

        // Directed tests with D=20, tRAS=3, tRP=2 (tRFC=5).
        cfg_rate_div = 12'd20; cfg_tras = 5'd3; cfg_trp = 5'd2;
        do_reset();
        check(cmd == 2'd0 && cke && !acc_busy && !sr_enable, "R11",
              {cmd, cke, acc_busy, sr_enable}, 5'b00100);

        // Request during the refresh pair: busy, not granted, held off.
        wait_aref();
        acc_req = 1'b1;
        check(acc_busy == 1'b1, "R10", acc_busy, 1);
        tick(1);
        check(acc_busy == 1'b1 && cmd == 2'd0, "R10", {acc_busy, cmd}, 3'b100);
        wait_grant();
        check(act_cyc - aref_cyc > 5, "R3", act_cyc - aref_cyc, 6);
        tick(2);
        finish_access(dc);
        tick(3);

        // Long access spanning several intervals: one deferred refresh pair.
        wait_aref();
        wait_grant();
        p0 = n_pre;
        tick(60);
        check(n_pre == p0, "R9", n_pre - p0, 0);
        finish_access(dc);
        tick(12);
        check(n_pre - p0 == 1 && pre_cyc == dc + 2, "R9", pre_cyc - dc, 2);
        check(n_aref == 0 || aref_cyc - pre_cyc == 3, "R9", aref_cyc - pre_cyc, 3);

        // Self-refresh requested while an access is in flight.
        wait_aref();
        wait_grant();
        pulse_sr();
        tick(4);
        check(cke == 1'b1 && sr_enable == 1'b1, "R4", {cke, sr_enable}, 2'b11);
        finish_access(dc);
        tick(3);
        check(cke == 1'b0 && fall_cyc == dc + 2, "R4", fall_cyc - dc, 2);

        // Long stay with no request: quiet and still low.
        l0 = n_low_cmd;
        tick(100);
        check(cke == 1'b0, "R6", cke, 0);
        check(n_low_cmd == l0, "R5", n_low_cmd - l0, 0);

        // Exit on access request.
        r0 = n_aref;
        wait_grant();
        check(pre_cyc - rise_cyc == 5, "R7", pre_cyc - rise_cyc, 5);
        check(aref_cyc - pre_cyc == 3 && n_aref - r0 == 1, "R7", aref_cyc - pre_cyc, 3);
        check(act_cyc - aref_cyc == 6, "R7", act_cyc - aref_cyc, 6);
        check(sr_enable == 1'b0, "R8", sr_enable, 0);
        tick(2);
        finish_access(dc);
        tick(10);
        check(cke == 1'b1, "R8", cke, 1);

        // Minimum residency with the request present from entry.
        wait_aref();
        pulse_sr();
        while (cke) tick(1);
        acc_req = 1'b1;
        while (!cke) tick(1);
        check(rise_cyc - fall_cyc == 3, "R6", rise_cyc - fall_cyc, 3);
        wait_grant();
        check(act_cyc - aref_cyc == 6, "R3", act_cyc - aref_cyc, 6);
        finish_access(dc);
        tick(5);

        $display("test done: total=%0d bad=%0d", total, bad);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule